// File: doc/BRIEF.md
# Scaled Pixel Shift-Out Unit

This unit sits between a display fetch engine and the video output. On every clock it takes the most recently fetched display byte and turns it into one 3-bit RGB colour. It splits each byte into 8, 4 or 2 logical pixels, for a colour depth of 1, 2 or 4 bits per pixel. It holds each pixel on the output for a programmable number of clocks, which replicates pixels horizontally.

The decoded pixels sit in a small buffer. An index walks through the buffer and a scale down-counter sets how long each pixel stays on the output. When the index runs past the last pixel of the byte, the buffer reloads itself from the fetch input. The pulse that marks the first visible cycle of a line restarts the whole sequence.

A 16-entry palette turns each logical colour into an RGB value, and software can rewrite the palette through a one-entry write port. Outside the visible region, and on spacing lines between character rows, the output is forced to black and the sequencing state is held.

Top module: `pxl_shift_out`

## Requirements
- R1: After reset `rgb_out` is 0, and palette entry i holds the value i modulo 8.
- R2: In a cycle with `visible` low, `rgb_out` is 0 one clock later. The index, the scale counter and the buffer keep their values, so the pixel stream resumes where it stopped once `visible` returns.
- R3: In a cycle with `spacing` high, `rgb_out` is 0 one clock later, and the sequencing state is frozen in the same way as in R2.
- R4: In an active cycle with `line_start` high:
  - the buffer loads the pixels of `fetch_byte`;
  - the index becomes 0;
  - the scale counter restarts;
  - this applies even if the previous byte had not been fully shown.
- R5: Each pixel is held for `scale` active cycles. A `scale` of 0 behaves as 1.
- R6: `depth_sel` encodings are as follows, and the depth is sampled each time the buffer fills:
  - 0 gives 1 bit per pixel and 8 pixels per byte;
  - 1 gives 2 bits per pixel and 4 pixels per byte;
  - 2 and 3 both give 4 bits per pixel and 2 pixels per byte.
- R7: Pixel k of a byte is the field of depth bits whose most significant bit is byte bit 7 − k·depth. Pixels are therefore shown from the most significant bits down.
- R8: When the index steps past the last pixel of the buffered byte, the buffer reloads from the `fetch_byte` present in that cycle and the index returns to 0.
- R9: The colour of an active cycle appears on `rgb_out` one clock later as `palette[logical colour]`.
- R10: With `pal_we` high, the palette entry at `pal_waddr` takes the value `pal_wdata`. The new value applies to colours looked up from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| visible | input | 1 | Current cycle lies inside the visible region |
| spacing | input | 1 | Current line is a character-row spacing line |
| line_start | input | 1 | First visible cycle of a line |
| depth_sel | input | 2 | Colour depth select (see R6) |
| scale | input | SCALE_W (4) | Clocks per pixel |
| fetch_byte | input | 8 | Most recently fetched display byte |
| pal_we | input | 1 | Palette write enable |
| pal_waddr | input | 4 | Palette entry to write |
| pal_wdata | input | 3 | RGB value to write |
| rgb_out | output | 3 | Registered RGB colour |

## Verification
A corrupted index or scale counter shows up within one pixel period as a colour taken from the wrong field of the byte. A missed buffer reload shows up at the next byte boundary as the previous byte's pixels repeating. If the state kept moving during a blanked gap, every pixel after the gap would be shifted by the length of the gap. The directed scenarios check each cycle of every line, including the cycles around each gap, so such errors show one clock after the cycle that caused them. Palette errors show on the first pixel that uses the affected entry.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  localparam int BYTE_W  = 8;
  localparam int PIX_MAX = 8;
  localparam int COLOR_W = 4;
  localparam int RGB_W   = 3;
  localparam int PAL_N   = 1 << COLOR_W;
  localparam int IDX_W   = $clog2(PIX_MAX);
  localparam int CNT_W   = IDX_W + 1;

  typedef enum logic [1:0] {
    DEPTH_1  = 2'd0,
    DEPTH_2  = 2'd1,
    DEPTH_4  = 2'd2,
    DEPTH_4B = 2'd3
  } depth_e;

  typedef logic [PIX_MAX-1:0][COLOR_W-1:0] pix_buf_t;

  function automatic logic [CNT_W-1:0] pix_count(input depth_e d);
    case (d)
      DEPTH_1: pix_count = CNT_W'(8);
      DEPTH_2: pix_count = CNT_W'(4);
      default: pix_count = CNT_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/pxl_rst_sync.sv
module pxl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pxl_unpack.sv
module pxl_unpack
  import pxl_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  input  depth_e            depth,
  output pix_buf_t          pix
);
  pix_buf_t p1, p2, p4;

  for (genvar k = 0; k < PIX_MAX; k++) begin : g_pix
    assign p1[k] = {{(COLOR_W-1){1'b0}}, byte_in[BYTE_W-1-k]};
    if (k < BYTE_W/2) begin : g_d2
      assign p2[k] = {2'b00, byte_in[BYTE_W-1-2*k -: 2]};
    end else begin : g_d2_pad
      assign p2[k] = '0;
    end
    if (k < BYTE_W/4) begin : g_d4
      assign p4[k] = byte_in[BYTE_W-1-4*k -: 4];
    end else begin : g_d4_pad
      assign p4[k] = '0;
    end
  end

  always_comb begin
    case (depth)
      DEPTH_1: pix = p1;
      DEPTH_2: pix = p2;
      default: pix = p4;
    endcase
  end
endmodule

// File: rtl/pxl_pacer.sv
module pxl_pacer
  import pxl_pkg::*;
#(
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               line_start,
  input  logic [SCALE_W-1:0] scale_eff,
  input  logic [CNT_W-1:0]   count,
  output logic [IDX_W-1:0]   idx_q,
  output logic [IDX_W-1:0]   idx_n,
  output logic               fill
);
  logic [SCALE_W-1:0] cnt_q, cnt_n, cnt_ld;
  logic [CNT_W-1:0]   idx_inc;

  assign idx_inc = CNT_W'(idx_q) + CNT_W'(1);

  always_comb begin
    fill   = 1'b0;
    idx_n  = idx_q;
    cnt_ld = cnt_q;
    if (active) begin
      if (line_start) begin
        cnt_ld = scale_eff;
        idx_n  = '0;
        fill   = 1'b1;
      end else if (cnt_q == '0) begin
        cnt_ld = scale_eff;
        if (idx_inc == count) begin
          idx_n = '0;
          fill  = 1'b1;
        end else begin
          idx_n = idx_inc[IDX_W-1:0];
        end
      end
    end
    cnt_n = active ? cnt_ld - SCALE_W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (active) begin
      idx_q <= idx_n;
      cnt_q <= cnt_n;
    end
  end

  // R3
  frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> ($stable(idx_q) && $stable(cnt_q)));

  // R5
  hold_while_counting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !line_start && cnt_q != '0) |=> $stable(idx_q));

  // R4
  line_start_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && line_start) |=> (idx_q == '0));

  // R8
  index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(idx_q) < count);
endmodule

// File: rtl/pxl_palette.sv
module pxl_palette
  import pxl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [COLOR_W-1:0] waddr,
  input  logic [RGB_W-1:0]   wdata,
  input  logic [COLOR_W-1:0] raddr,
  output logic [RGB_W-1:0]   rdata
);
  logic [PAL_N-1:0][RGB_W-1:0] ent_q;

  for (genvar i = 0; i < PAL_N; i++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (waddr == COLOR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[i] <= RGB_W'(i % 8);
      else if (ent_en) ent_q[i] <= wdata;
    end
  end

  assign rdata = ent_q[raddr];

  // R10
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ent_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/pxl_shift_out.sv
module pxl_shift_out
  import pxl_pkg::*;
#(
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               visible,
  input  logic               spacing,
  input  logic               line_start,
  input  logic [1:0]         depth_sel,
  input  logic [SCALE_W-1:0] scale,
  input  logic [7:0]         fetch_byte,
  input  logic               pal_we,
  input  logic [3:0]         pal_waddr,
  input  logic [2:0]         pal_wdata,
  output logic [2:0]         rgb_out
);
  logic               rst_s_n;
  logic               active;
  logic [SCALE_W-1:0] scale_eff;
  depth_e             depth_q, depth_n, depth_in;
  pix_buf_t           buf_q, buf_n, unpacked;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic               fill;
  logic [RGB_W-1:0]   pal_rd, rgb_q, rgb_n;

  pxl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign active    = visible && !spacing;
  assign scale_eff = (scale == '0) ? SCALE_W'(1) : scale;
  assign depth_in  = depth_e'(depth_sel);

  pxl_unpack u_unpack (
    .byte_in (fetch_byte),
    .depth   (depth_in),
    .pix     (unpacked)
  );

  pxl_pacer #(.SCALE_W(SCALE_W)) u_pacer (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .active     (active),
    .line_start (line_start),
    .scale_eff  (scale_eff),
    .count      (pix_count(depth_q)),
    .idx_q      (idx_q),
    .idx_n      (idx_n),
    .fill       (fill)
  );

  always_comb begin
    buf_n   = fill ? unpacked : buf_q;
    depth_n = fill ? depth_in : depth_q;
  end

  pxl_palette u_pal (
    .clk   (clk),
    .rst_n (rst_s_n),
    .we    (pal_we),
    .waddr (pal_waddr),
    .wdata (pal_wdata),
    .raddr (buf_n[idx_n]),
    .rdata (pal_rd)
  );

  assign rgb_n = active ? pal_rd : '0;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      buf_q   <= '0;
      depth_q <= DEPTH_1;
    end else if (fill) begin
      buf_q   <= buf_n;
      depth_q <= depth_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rgb_q <= '0;
    else          rgb_q <= rgb_n;
  end

  assign rgb_out = rgb_q;

  // R2
  blank_output_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !active |=> (rgb_out == '0));

  // R8
  buffer_static_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !fill |=> $stable(buf_q));
endmodule

// File: tb/pxl_shift_out_tb.sv
module pxl_shift_out_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       visible, spacing, line_start;
  logic [1:0] depth_sel;
  logic [3:0] scale;
  logic [7:0] fetch_byte;
  logic       pal_we;
  logic [3:0] pal_waddr;
  logic [2:0] pal_wdata;
  logic [2:0] rgb_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] pal_m [16];
  logic [7:0] bseq [8];

  always #2.5 clk = ~clk;

  pxl_shift_out u_dut (
    .clk(clk), .rst_n(rst_n), .visible(visible), .spacing(spacing),
    .line_start(line_start), .depth_sel(depth_sel), .scale(scale),
    .fetch_byte(fetch_byte), .pal_we(pal_we), .pal_waddr(pal_waddr),
    .pal_wdata(pal_wdata), .rgb_out(rgb_out)
  );

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: rgb_out=%0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int bits_of(input logic [1:0] d);
    return (d == 2'd0) ? 1 : (d == 2'd1) ? 2 : 4;
  endfunction

  // R7: pixel k is the depth-wide field starting at bit 7 - k*depth
  function automatic int colour_of(input logic [7:0] b, input logic [1:0] d, input int k);
    int w = bits_of(d);
    return (int'(b) >> (8 - w * (k + 1))) & ((1 << w) - 1);
  endfunction

  task automatic idle_cycle(input bit vis, input bit sp);
    @(negedge clk);
    visible = vis; spacing = sp; line_start = 1'b0; fetch_byte = 8'hA5;
    @(posedge clk); #1;
  endtask

  task automatic run_line(input string req, input logic [1:0] d, input int sc, input int n,
                          input int gap_at, input int gap_len, input bit gap_sp);
    int s   = (sc == 0) ? 1 : sc;
    int cnt = 8 / bits_of(d);
    for (int j = 0; j < n; j++) begin
      if (j == gap_at) begin
        for (int g = 0; g < gap_len; g++) begin
          idle_cycle(gap_sp, gap_sp);
          check(gap_sp ? "R3 spacing blank" : "R2 invisible blank", rgb_out, 3'd0);
        end
      end
      @(negedge clk);
      visible = 1'b1; spacing = 1'b0; line_start = (j == 0);
      depth_sel = d; scale = 4'(sc); fetch_byte = bseq[j / (s * cnt)];
      @(posedge clk); #1;
      check(req, rgb_out, pal_m[colour_of(bseq[j / (s * cnt)], d, (j / s) % cnt)]);
    end
    idle_cycle(1'b0, 1'b0);
    check("R2 end of line", rgb_out, 3'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; visible = 0; spacing = 0; line_start = 0; depth_sel = 0;
    scale = 4'd1; fetch_byte = 0; pal_we = 0; pal_waddr = 0; pal_wdata = 0;
    for (int i = 0; i < 16; i++) pal_m[i] = 3'(i % 8);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    check("R1 reset output", rgb_out, 3'd0);
  endtask

  task automatic t_depth1();
    bseq[0] = 8'b1011_0010; bseq[1] = 8'b0110_1001; bseq[2] = 8'hF0;
    run_line("R6 R7 R8 1bpp", 2'd0, 1, 24, -1, 0, 0);
  endtask

  task automatic t_depth2_scaled();
    bseq[0] = 8'b00_01_10_11; bseq[1] = 8'b11_10_01_00; bseq[2] = 8'b10_00_11_01;
    run_line("R5 R7 R8 2bpp x3", 2'd1, 3, 36, -1, 0, 0);
  endtask

  task automatic t_depth4_palette_reset();
    bseq[0] = 8'hD2; bseq[1] = 8'h9F; bseq[2] = 8'h7C;
    run_line("R1 R6 4bpp reset palette", 2'd2, 2, 12, -1, 0, 0);
  endtask

  task automatic t_depth3_alias();
    bseq[0] = 8'h3E; bseq[1] = 8'hB4; bseq[2] = 8'h61;
    run_line("R6 code 3 is 4bpp", 2'd3, 1, 6, -1, 0, 0);
  endtask

  task automatic t_scale_zero();
    bseq[0] = 8'b01_11_00_10; bseq[1] = 8'b10_01_11_00;
    run_line("R5 scale 0 as 1", 2'd1, 0, 8, -1, 0, 0);
  endtask

  task automatic t_restart();
    bseq[0] = 8'b1100_1010; bseq[1] = 8'h0F;
    run_line("R4 partial line", 2'd0, 2, 5, -1, 0, 0);
    bseq[0] = 8'b0101_0011; bseq[1] = 8'hC3;
    run_line("R4 restart", 2'd0, 2, 20, -1, 0, 0);
  endtask

  task automatic t_spacing_gap();
    bseq[0] = 8'b11_01_10_00; bseq[1] = 8'b00_11_01_10; bseq[2] = 8'h5A;
    run_line("R3 resume after spacing", 2'd1, 2, 20, 5, 3, 1);
  endtask

  task automatic t_invisible_gap();
    bseq[0] = 8'b1001_0110; bseq[1] = 8'b0111_1000;
    run_line("R2 resume after blank", 2'd0, 2, 24, 7, 4, 0);
  endtask

  task automatic t_palette_write();
    @(negedge clk);
    pal_we = 1'b1; pal_waddr = 4'd5; pal_wdata = 3'b010;
    @(negedge clk);
    pal_waddr = 4'd13; pal_wdata = 3'b111;
    @(negedge clk);
    pal_we = 1'b0;
    pal_m[5] = 3'b010; pal_m[13] = 3'b111;
    bseq[0] = 8'h5D; bseq[1] = 8'hD5; bseq[2] = 8'h35;
    run_line("R10 R9 palette write", 2'd2, 1, 6, -1, 0, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: rgb_out=%0d expected completion", rgb_out);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_depth1();
    t_depth2_scaled();
    t_depth4_palette_reset();
    t_depth3_alias();
    t_scale_zero();
    t_restart();
    t_spacing_gap();
    t_invisible_gap();
    t_palette_write();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule